// File: doc/BRIEF.md
# Control Flow Signature Monitor

The monitor watches the stream of committed program counters of a processor and detects illegal transfers between basic blocks. Software loads a small table with one entry per basic block: the block's start address, the signature assigned to that block, and a difference value. The difference value is the XOR of the signature of the block's legal predecessor and the block's own signature. A runtime signature register follows execution. Each time a committed PC equals the start address of a table entry, the register is stepped by XOR with that entry's difference value, and the result is compared with the entry's signature.

A mismatch means the program arrived from a block that is not the legal predecessor. The monitor then raises a sticky error flag and captures the faulting PC. It also resynchronises the runtime register to the signature of the block that was entered. A wrong jump that lands inside the block currently running never touches a start address, so the monitor cannot see it.

Every committed PC is given a transfer class, which appears on a registered output one cycle later. The classes are: stays inside a block, legal entry into a different block, passing re-entry into the block already running, and failing entry. Until the first entry into a block, the runtime register follows the signature held in table entry 0, which is the program entry block.

Top module: `cfsm_monitor`

## Requirements
- R1: After reset, err_flag is 0, err_pc is 0, cur_sig is 0 and xfer_class is 0 (no commit). No table entry is valid after reset.
- R2: Until the first commit that hits a table entry, cur_sig follows the signature of table entry 0. A write to entry 0 shows on cur_sig two clock edges after the write is sampled. cur_sig is 0 while entry 0 is not valid.
- R3: A commit whose PC equals the start address of a valid entry i passes when (cur_sig XOR diff[i]) equals sig[i]. On a pass, cur_sig takes that value, and xfer_class becomes 2 (legal) if i differs from the block currently running or no block has been entered yet. Otherwise xfer_class becomes 3 (re-entry).
- R4: A commit that hits entry i and does not pass sets err_flag to 1 and err_pc to the commit PC. It also loads cur_sig with sig[i] and gives xfer_class 4 (fault).
- R5: A commit whose PC matches no valid start address leaves cur_sig and the error state unchanged and gives xfer_class 1 (inside a block). This holds even when the PC jumps within the block.
- R6: Once set, err_flag stays 1. err_pc keeps the first faulting PC through later faults until clr_err is applied.
- R7: A clr_err pulse clears err_flag and err_pc to 0 on the next edge. If a fault is sampled in the same cycle, the fault wins: err_flag is 1 and err_pc is the PC of that fault.
- R8: When several valid entries share the committed start address, the entry with the lowest index is used.
- R9: A table write sampled in the same cycle as a commit does not affect that commit's lookup. The commit uses the table contents from before the write.
- R10: A cycle without commit_valid gives xfer_class 0 and leaves cur_sig unchanged once a block has been entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| commit_valid | input | 1 | A PC is committed this cycle |
| commit_pc | input | 32 | Committed program counter |
| clr_err | input | 1 | Pulse that clears the error flag and the captured PC |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_idx | input | 5 | Index of the entry written |
| tbl_start | input | 32 | Start address of the block |
| tbl_sig | input | 16 | Signature of the block |
| tbl_diff | input | 16 | Difference value, predecessor signature XOR own signature |
| err_flag | output | 1 | Sticky control flow error flag |
| err_pc | output | 32 | PC of the first faulting block entry |
| cur_sig | output | 16 | Runtime signature register |
| xfer_class | output | 3 | Class of the previous cycle's commit: 0 none, 1 inside block, 2 legal, 3 re-entry, 4 fault |

## Verification
A clear pulse and a new failing block entry can be sampled in the same cycle. The bench provokes this by asserting clr_err while a commit enters a block from a wrong predecessor, after an earlier fault has already been captured. It judges the result by checking that err_flag stays set and that err_pc now holds the new faulting PC instead of being cleared. A table write and a lookup of the same entry are also driven in one cycle. The bench checks that the commit's class and signature follow the old entry contents and that the next entry into that block follows the new contents.

// File: rtl/cfsm_pkg.sv
package cfsm_pkg;
  typedef enum logic [2:0] {
    XC_NONE  = 3'd0,
    XC_SAME  = 3'd1,
    XC_LEGAL = 3'd2,
    XC_ALIAS = 3'd3,
    XC_FAULT = 3'd4
  } xfer_cls_e;
endpackage

// File: rtl/cfsm_table.sv
module cfsm_table #(
  parameter int AW = 32,
  parameter int SW = 16,
  parameter int NE = 32,
  localparam int IW = $clog2(NE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [AW-1:0] wr_start,
  input  logic [SW-1:0] wr_sig,
  input  logic [SW-1:0] wr_diff,
  input  logic [AW-1:0] lk_pc,
  output logic          lk_hit,
  output logic [IW-1:0] lk_idx,
  output logic [SW-1:0] lk_sig,
  output logic [SW-1:0] lk_diff,
  output logic [SW-1:0] entry0_sig
);
  logic [AW-1:0] start_q [NE];
  logic [SW-1:0] sig_q   [NE];
  logic [SW-1:0] diff_q  [NE];
  logic [NE-1:0] valid_q;
  logic [NE-1:0] match;
  logic [NE-1:0] grant;

  // storage: contents without reset, valid bits with reset
  generate
    for (genvar g = 0; g < NE; g++) begin : g_ent
      logic ent_we;
      assign ent_we = wr_en && (wr_idx == IW'(g));
      always_ff @(posedge clk) begin
        if (ent_we) begin
          start_q[g] <= wr_start;
          sig_q[g]   <= wr_sig;
          diff_q[g]  <= wr_diff;
        end
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      valid_q[g] <= 1'b0;
        else if (ent_we) valid_q[g] <= 1'b1;
      end
      assign match[g] = valid_q[g] && (start_q[g] == lk_pc);
    end
  endgenerate

  // lowest index wins
  always_comb begin
    logic lower;
    lower   = 1'b0;
    grant   = '0;
    lk_idx  = '0;
    lk_sig  = '0;
    lk_diff = '0;
    for (int i = 0; i < NE; i++) begin
      grant[i] = match[i] && !lower;
      lower    = lower || match[i];
      if (grant[i]) begin
        lk_idx  = IW'(i);
        lk_sig  = sig_q[i];
        lk_diff = diff_q[i];
      end
    end
  end

  assign lk_hit     = |match;
  assign entry0_sig = valid_q[0] ? sig_q[0] : '0;

  // R8
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  // R8
  hit_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (grant[lk_idx] && match[lk_idx]));
endmodule

// File: rtl/cfsm_check.sv
module cfsm_check
  import cfsm_pkg::*;
#(
  parameter int AW = 32,
  parameter int SW = 16,
  parameter int NE = 32,
  localparam int IW = $clog2(NE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit_valid,
  input  logic [AW-1:0] commit_pc,
  input  logic          clr_err,
  input  logic          hit,
  input  logic [IW-1:0] hit_idx,
  input  logic [SW-1:0] hit_sig,
  input  logic [SW-1:0] hit_diff,
  input  logic [SW-1:0] entry0_sig,
  output logic          err_flag,
  output logic [AW-1:0] err_pc,
  output logic [SW-1:0] cur_sig,
  output xfer_cls_e     xfer_class
);
  logic [SW-1:0] sig_q,   sig_n;
  logic [IW-1:0] idx_q,   idx_n;
  logic          started_q, started_n;
  logic          err_q,   err_n;
  logic [AW-1:0] epc_q,   epc_n;
  xfer_cls_e     cls_q,   cls_n;
  logic [SW-1:0] stepped;
  logic          entry_ok;
  logic          fault_now;

  assign stepped   = sig_q ^ hit_diff;
  assign entry_ok  = (stepped == hit_sig);
  assign fault_now = commit_valid && hit && !entry_ok;

  always_comb begin
    sig_n     = sig_q;
    idx_n     = idx_q;
    started_n = started_q;
    err_n     = err_q;
    epc_n     = epc_q;
    cls_n     = XC_NONE;
    if (!started_q) sig_n = entry0_sig;
    if (clr_err) begin
      err_n = 1'b0;
      epc_n = '0;
    end
    if (commit_valid) begin
      if (!hit) begin
        cls_n = XC_SAME;
      end else begin
        started_n = 1'b1;
        idx_n     = hit_idx;
        if (entry_ok) begin
          sig_n = stepped;
          cls_n = (started_q && hit_idx == idx_q) ? XC_ALIAS : XC_LEGAL;
        end else begin
          sig_n = hit_sig;
          cls_n = XC_FAULT;
          if (!err_q || clr_err) begin
            err_n = 1'b1;
            epc_n = commit_pc;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_q     <= '0;
      idx_q     <= '0;
      started_q <= 1'b0;
      err_q     <= 1'b0;
      epc_q     <= '0;
      cls_q     <= XC_NONE;
    end else begin
      sig_q     <= sig_n;
      idx_q     <= idx_n;
      started_q <= started_n;
      err_q     <= err_n;
      epc_q     <= epc_n;
      cls_q     <= cls_n;
    end
  end

  assign err_flag   = err_q;
  assign err_pc     = epc_q;
  assign cur_sig    = sig_q;
  assign xfer_class = cls_q;

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !clr_err) |=> err_q);
  // R6
  errpc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !clr_err) |=> $stable(epc_q));
  // R4
  fault_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_q == XC_FAULT) |-> err_q);
  // R5
  intra_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_valid && !hit && started_q) |=> $stable(sig_q));
  // R7
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_err && !fault_now) |=> !err_q);
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit_valid && started_q) |=> $stable(sig_q));
endmodule

// File: rtl/cfsm_monitor.sv
module cfsm_monitor #(
  parameter int AW = 32,
  parameter int SW = 16,
  parameter int NE = 32,
  localparam int IW = $clog2(NE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit_valid,
  input  logic [AW-1:0] commit_pc,
  input  logic          clr_err,
  input  logic          tbl_we,
  input  logic [IW-1:0] tbl_idx,
  input  logic [AW-1:0] tbl_start,
  input  logic [SW-1:0] tbl_sig,
  input  logic [SW-1:0] tbl_diff,
  output logic          err_flag,
  output logic [AW-1:0] err_pc,
  output logic [SW-1:0] cur_sig,
  output logic [2:0]    xfer_class
);
  logic [1:0]    rst_pipe;
  logic          rst_sync_n;
  logic          lk_hit;
  logic [IW-1:0] lk_idx;
  logic [SW-1:0] lk_sig;
  logic [SW-1:0] lk_diff;
  logic [SW-1:0] e0_sig;
  cfsm_pkg::xfer_cls_e cls;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  cfsm_table #(.AW(AW), .SW(SW), .NE(NE)) u_tbl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (tbl_we),
    .wr_idx     (tbl_idx),
    .wr_start   (tbl_start),
    .wr_sig     (tbl_sig),
    .wr_diff    (tbl_diff),
    .lk_pc      (commit_pc),
    .lk_hit     (lk_hit),
    .lk_idx     (lk_idx),
    .lk_sig     (lk_sig),
    .lk_diff    (lk_diff),
    .entry0_sig (e0_sig)
  );

  cfsm_check #(.AW(AW), .SW(SW), .NE(NE)) u_chk (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .commit_valid (commit_valid),
    .commit_pc    (commit_pc),
    .clr_err      (clr_err),
    .hit          (lk_hit),
    .hit_idx      (lk_idx),
    .hit_sig      (lk_sig),
    .hit_diff     (lk_diff),
    .entry0_sig   (e0_sig),
    .err_flag     (err_flag),
    .err_pc       (err_pc),
    .cur_sig      (cur_sig),
    .xfer_class   (cls)
  );

  assign xfer_class = cls;
endmodule

// File: tb/sim_cfsm_monitor.sv
`timescale 1ns/1ps
module sim_cfsm_monitor;
  localparam int NE = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        commit_valid = 1'b0;
  logic [31:0] commit_pc = '0;
  logic        clr_err = 1'b0;
  logic        tbl_we = 1'b0;
  logic [4:0]  tbl_idx = '0;
  logic [31:0] tbl_start = '0;
  logic [15:0] tbl_sig = '0;
  logic [15:0] tbl_diff = '0;
  logic        err_flag;
  logic [31:0] err_pc;
  logic [15:0] cur_sig;
  logic [2:0]  xfer_class;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // bench model of the requirements
  logic [31:0] t_start [NE];
  logic [15:0] t_sig   [NE];
  logic [15:0] t_diff  [NE];
  logic        t_val   [NE];
  logic [15:0] m_sig = '0;
  int          m_idx = 0;
  bit          m_started = 1'b0;
  logic        m_err = 1'b0;
  logic [31:0] m_epc = '0;
  logic [2:0]  m_cls = 3'd0;

  always #5 clk = ~clk;

  cfsm_monitor u0 (
    .clk(clk), .rst_n(rst_n), .commit_valid(commit_valid), .commit_pc(commit_pc),
    .clr_err(clr_err), .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_start(tbl_start),
    .tbl_sig(tbl_sig), .tbl_diff(tbl_diff), .err_flag(err_flag), .err_pc(err_pc),
    .cur_sig(cur_sig), .xfer_class(xfer_class)
  );

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check(tag, "cur_sig", {16'h0, cur_sig}, {16'h0, m_sig});
    check(tag, "err_flag", {31'h0, err_flag}, {31'h0, m_err});
    check(tag, "err_pc", err_pc, m_epc);
    check(tag, "xfer_class", {29'h0, xfer_class}, {29'h0, m_cls});
  endtask

  // one clock: drive now (at a falling edge), advance the model, check
  task automatic cyc(input bit cv, input logic [31:0] pc, input bit clr, input bit we,
                     input int wi, input logic [31:0] ws, input logic [15:0] wsg,
                     input logic [15:0] wd, input string tag);
    logic [15:0] n_sig;
    logic [15:0] stp;
    int          n_idx;
    bit          n_st;
    logic        n_err;
    logic [31:0] n_epc;
    logic [2:0]  n_cls;
    int          h;
    commit_valid = cv; commit_pc = pc; clr_err = clr;
    tbl_we = we; tbl_idx = wi[4:0]; tbl_start = ws; tbl_sig = wsg; tbl_diff = wd;
    @(negedge clk);
    n_sig = m_sig; n_idx = m_idx; n_st = m_started; n_err = m_err; n_epc = m_epc;
    n_cls = 3'd0;
    if (!m_started) n_sig = t_val[0] ? t_sig[0] : 16'h0;
    if (clr) begin n_err = 1'b0; n_epc = '0; end
    if (cv) begin
      h = -1;
      for (int i = NE - 1; i >= 0; i--) if (t_val[i] && t_start[i] == pc) h = i;
      if (h < 0) n_cls = 3'd1;
      else begin
        stp = m_sig ^ t_diff[h];
        n_st = 1'b1; n_idx = h;
        if (stp == t_sig[h]) begin
          n_sig = stp;
          n_cls = (m_started && h == m_idx) ? 3'd3 : 3'd2;
        end else begin
          n_sig = t_sig[h];
          n_cls = 3'd4;
          if (!m_err || clr) begin n_err = 1'b1; n_epc = pc; end
        end
      end
    end
    if (we) begin
      t_start[wi] = ws; t_sig[wi] = wsg; t_diff[wi] = wd; t_val[wi] = 1'b1;
    end
    m_sig = n_sig; m_idx = n_idx; m_started = n_st; m_err = n_err; m_epc = n_epc;
    m_cls = n_cls;
    check_all(tag);
    commit_valid = 1'b0; clr_err = 1'b0; tbl_we = 1'b0;
  endtask

  task automatic idle(input string tag);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic commit(input logic [31:0] pc, input string tag);
    cyc(1, pc, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic wr(input int i, input logic [31:0] s, input logic [15:0] g,
                    input logic [15:0] d, input string tag);
    cyc(0, 0, 0, 1, i, s, g, d, tag);
  endtask

  task automatic t_reset();
    for (int i = 0; i < NE; i++) t_val[i] = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R1");
    idle("R1");
  endtask

  task automatic t_load();
    wr(0, 32'h100, 16'h1234, 16'h0000, "R2");
    idle("R2");
    check("R2", "cur_sig after entry0 load", {16'h0, cur_sig}, 32'h1234);
    wr(0, 32'h100, 16'h1111, 16'h0000, "R2");
    idle("R2");
    wr(1, 32'h200, 16'h2222, 16'h3333, "R2");
    wr(2, 32'h300, 16'h4444, 16'h6666, "R2");
    wr(3, 32'h400, 16'h8888, 16'hCCCC, "R2");
    check("R2", "cur_sig tracks entry0", {16'h0, cur_sig}, 32'h1111);
  endtask

  task automatic t_legal();
    commit(32'h100, "R3");
    check("R3", "first entry legal", {29'h0, xfer_class}, 32'd2);
    commit(32'h100, "R3");
    check("R3", "re-entry class", {29'h0, xfer_class}, 32'd3);
    commit(32'h104, "R5");
    commit(32'h200, "R3");
    idle("R10");
    check("R10", "idle class", {29'h0, xfer_class}, 32'd0);
    commit(32'h300, "R3");
    check("R3", "sig after 0x300", {16'h0, cur_sig}, 32'h4444);
  endtask

  task automatic t_intra();
    commit(32'h304, "R5");
    commit(32'h31C, "R5");
    check("R5", "no error on jump in block", {31'h0, err_flag}, 32'd0);
    commit(32'h400, "R3");
  endtask

  task automatic t_fault();
    commit(32'h200, "R4");
    check("R4", "fault pc", err_pc, 32'h200);
    check("R4", "resync sig", {16'h0, cur_sig}, 32'h2222);
    commit(32'h400, "R6");
    check("R6", "first pc kept", err_pc, 32'h200);
    idle("R6");
  endtask

  task automatic t_clear();
    cyc(0, 0, 1, 0, 0, 0, 0, 0, "R7");
    check("R7", "flag cleared", {31'h0, err_flag}, 32'd0);
    commit(32'h100, "R4");
    cyc(1, 32'h300, 1, 0, 0, 0, 0, 0, "R7");
    check("R7", "fault beats clear", err_pc, 32'h300);
    cyc(0, 0, 1, 0, 0, 0, 0, 0, "R7");
  endtask

  task automatic t_prio();
    wr(5, 32'h300, 16'h9999, 16'h0000, "R8");
    commit(32'h200, "R8");
    cyc(0, 0, 1, 0, 0, 0, 0, 0, "R8");
    commit(32'h300, "R8");
    check("R8", "lowest index used", {29'h0, xfer_class}, 32'd2);
  endtask

  task automatic t_collide();
    cyc(1, 32'h400, 0, 1, 3, 32'h400, 16'h1234, 16'h0000, "R9");
    check("R9", "old entry used", {29'h0, xfer_class}, 32'd2);
    commit(32'h400, "R9");
    check("R9", "new entry used next", {29'h0, xfer_class}, 32'd4);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_load();
    t_legal();
    t_intra();
    t_fault();
    t_clear();
    t_prio();
    t_collide();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule